// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a soft model of a small programmable array-logic device. Sixteen array signals are used: eight dedicated inputs and eight feedback signals, one from each output cell. Each signal enters a programmable AND plane in both true and inverted form. Every product term is the AND of the columns its connection bits select. A fixed OR plane gives each of the eight output cells its own group of eight product terms. Each cell can work as a clocked register or as a combinational path. Each cell also has its own output polarity and its own choice of output-enable source.

Two global architecture bits and one local bit per cell select the cell behaviour. There are three architectures: registered, complex and simple. A clock-or-input pin and an enable-or-input pin work as register clock and output enable in the registered architecture. In the other two architectures they work as plain array inputs. The connection bits and the mode word load through a word-write port while a configuration-enable input holds every output undriven. A preload input loads the registers directly, bypassing the array, for test. Outputs are given as a value vector and an enable vector instead of true tristate pins.

Top module: `sop_fabric`

## Requirements
- R1: On synchronous reset all cell registers clear to 0 and all connection bits are set. The mode word resets to the simple architecture with every local bit 1 and every polarity bit 1, so no output is driven and every output value reads 0.
- R2: When cfgEn and cfgWe are both high, a write to address r in 0..63 stores the connection word of product-term row r. Bit 2k of that word connects signal k in true form and bit 2k+1 connects it inverted. Signals 0..7 are din[7:0] and signals 8..15 are the feedbacks of cells 0..7. Address 64 is the mode word: bit 0 = 1 selects a non-registered architecture, bit 1 = 1 selects complex (only when bit 0 is 1), bits 15:8 are the local bits of cells 7..0 and bits 23:16 are the polarity bits (1 = active-high). Writes to any other address are ignored.
- R3: While cfgEn is high, every bit of ioOe is 0.
- R4: A product term is the AND of its connected columns. A term that connects both forms of one signal is always 0, and a term with no connection is always 1. Cell i owns rows 8i to 8i+7, and its first term is row 8i.
- R5: In the simple architecture each cell value is the OR of all eight of its terms. A cell whose local bit is 0 is always driven, and a cell whose local bit is 1 is never driven.
- R6: In the complex architecture the first term of each cell drives its output enable, and the cell value is the OR of its other seven terms.
- R7: A cell with polarity bit 0 presents the inverse of its value on ioOut. This applies to combinational and registered cells alike.
- R8: In the registered architecture a cell with local bit 0 loads the OR of its eight terms on each clock edge at which ckPin is high. It shows the register content on ioOut and is driven exactly when gateN is low.
- R9: In the registered architecture a cell with local bit 1 is combinational: its first term is its enable and its other seven terms make its value.
- R10: A registered cell feeds its register content back into the array, and every other cell feeds back its ioIn bit. In the non-registered architectures, signal 8 carries ckPin and signal 15 carries gateN in place of the feedback of cells 0 and 7.
- R11: When preEn is high at a clock edge, all cell registers load preData. This takes priority over a normal load.
- R12: The registers hold their value at any edge without preload where ckPin is low, where cfgEn is high, or where the architecture is not registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgEn | input | 1 | Configuration enable; blocks all outputs |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 7 | Configuration word address |
| cfgData | input | 32 | Configuration write data |
| din | input | 8 | Dedicated array inputs |
| ckPin | input | 1 | Register clock enable or plain array input |
| gateN | input | 1 | Active-low output enable or plain array input |
| ioIn | input | 8 | Values seen on the I/O pins |
| preEn | input | 1 | Register preload strobe |
| preData | input | 8 | Register preload value |
| ioOut | output | 8 | Cell output values |
| ioOe | output | 8 | Cell output enables |

## Verification
The bench targets the unusual product terms. A term with both forms of one signal must read 0, and a design that ignores the inverted column would follow the input instead. An empty term must read 1, and a design that reduces it with OR would read 0. It checks that the first term switches from enable to data between the architectures, so a cell that sums all eight terms in complex mode shows up as a wrong value. It checks the substitution of the two dual-role pins into the array and the one-edge delay of feedback between registered cells, which would fail if feedback came from the pin. It also checks that preload beats a normal load and that a register holds when ckPin is low.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    ARCH_REG    = 2'd0,
    ARCH_CPLX   = 2'd1,
    ARCH_SIMPLE = 2'd2
  } arch_e;

  typedef struct packed {
    logic capture;
    logic preload;
    logic block;
  } strobe_t;

endpackage

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int NUM_TERMS = 8,
  parameter int NUM_COLS  = 32,
  localparam int NUM_ROWS = NUM_CELLS * NUM_TERMS,
  localparam int ADDR_W   = $clog2(NUM_ROWS + 1)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfgEn,
  input  logic                               cfgWe,
  input  logic [ADDR_W-1:0]                  cfgAddr,
  input  logic [NUM_COLS-1:0]                cfgData,
  input  logic                               ckPin,
  input  logic                               preEn,
  output logic [NUM_ROWS-1:0][NUM_COLS-1:0]  fuseMap,
  output arch_e                              arch,
  output logic [NUM_CELLS-1:0]               cellLocal,
  output logic [NUM_CELLS-1:0]               cellPol,
  output strobe_t                            strobes
);

  localparam int ROW_W     = $clog2(NUM_ROWS);
  localparam int LOCAL_LSB = 8;
  localparam int POL_LSB   = LOCAL_LSB + NUM_CELLS;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_ROWS);

  logic combArch;
  logic cplxArch;
  logic writeHit;

  assign writeHit = cfgEn & cfgWe;

  // Connection bits and mode word; reset leaves every row connected to all columns
  always_ff @(posedge clk) begin
    if (rst) begin
      fuseMap   <= '1;
      combArch  <= 1'b1;
      cplxArch  <= 1'b0;
      cellLocal <= '1;
      cellPol   <= '1;
    end else if (writeHit) begin
      if (cfgAddr < MODE_ADDR) begin
        fuseMap[cfgAddr[ROW_W-1:0]] <= cfgData;
      end else if (cfgAddr == MODE_ADDR) begin
        combArch  <= cfgData[0];
        cplxArch  <= cfgData[1];
        cellLocal <= cfgData[LOCAL_LSB +: NUM_CELLS];
        cellPol   <= cfgData[POL_LSB +: NUM_CELLS];
      end
    end
  end

  always_comb begin
    if (!combArch)     arch = ARCH_REG;
    else if (cplxArch) arch = ARCH_CPLX;
    else               arch = ARCH_SIMPLE;
  end

  // Strobes to the datapath: preload wins over a normal load, config freezes loads
  always_comb begin
    strobes.block   = cfgEn;
    strobes.preload = preEn;
    strobes.capture = (arch == ARCH_REG) && ckPin && !cfgEn && !preEn;
  end

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (rst)
    (writeHit && cfgAddr == MODE_ADDR) |=>
      (cellLocal == $past(cfgData[LOCAL_LSB +: NUM_CELLS]) &&
       cellPol   == $past(cfgData[POL_LSB +: NUM_CELLS])));

  // R12
  no_capture_off_arch_chk: assert property (@(posedge clk) disable iff (rst)
    (combArch || !ckPin || cfgEn) |-> !strobes.capture);

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  arch_e                 arch,
  input  logic                  cellLocal,
  input  logic                  cellPol,
  input  logic [NUM_TERMS-1:0]  terms,
  input  logic                  regQ,
  input  logic                  gateN,
  output logic                  regD,
  output logic                  cellOut,
  output logic                  cellOe
);

  logic isReg;
  logic sumAll;
  logic sumRest;
  logic cellVal;

  always_comb begin
    isReg   = (arch == ARCH_REG) && !cellLocal;
    sumAll  = |terms;
    sumRest = |terms[NUM_TERMS-1:1];
    regD    = sumAll;
    if (isReg) begin
      cellVal = regQ;
      cellOe  = ~gateN;
    end else if (arch == ARCH_SIMPLE) begin
      cellVal = sumAll;
      cellOe  = ~cellLocal;
    end else begin
      cellVal = sumRest;
      cellOe  = terms[0];
    end
    cellOut = cellPol ? cellVal : ~cellVal;
  end

endmodule

// File: rtl/sop_datapath.sv
module sop_datapath
  import sop_pkg::*;
#(
  parameter int NUM_IN    = 8,
  parameter int NUM_CELLS = 8,
  parameter int NUM_TERMS = 8,
  localparam int NUM_SIG  = NUM_IN + NUM_CELLS,
  localparam int NUM_COLS = 2 * NUM_SIG,
  localparam int NUM_ROWS = NUM_CELLS * NUM_TERMS
) (
  input  logic                               clk,
  input  logic                               rst,
  input  strobe_t                            strobes,
  input  arch_e                              arch,
  input  logic [NUM_CELLS-1:0]               cellLocal,
  input  logic [NUM_CELLS-1:0]               cellPol,
  input  logic [NUM_ROWS-1:0][NUM_COLS-1:0]  fuseMap,
  input  logic [NUM_IN-1:0]                  din,
  input  logic                               ckPin,
  input  logic                               gateN,
  input  logic [NUM_CELLS-1:0]               ioIn,
  input  logic [NUM_CELLS-1:0]               preData,
  output logic [NUM_CELLS-1:0]               ioOut,
  output logic [NUM_CELLS-1:0]               ioOe
);

  logic [NUM_CELLS-1:0] regQ;
  logic [NUM_CELLS-1:0] regD;
  logic [NUM_CELLS-1:0] cellOe;
  logic [NUM_SIG-1:0]   sigVec;
  logic [NUM_COLS-1:0]  colVec;
  logic [NUM_ROWS-1:0]  rowVal;

  // Array signals: dedicated inputs, then one feedback per cell
  always_comb begin
    sigVec[NUM_IN-1:0] = din;
    for (int i = 0; i < NUM_CELLS; i++) begin
      if (arch == ARCH_REG && !cellLocal[i]) sigVec[NUM_IN+i] = regQ[i];
      else                                   sigVec[NUM_IN+i] = ioIn[i];
    end
    if (arch != ARCH_REG) begin
      sigVec[NUM_IN]    = ckPin;
      sigVec[NUM_SIG-1] = gateN;
    end
  end

  // True and inverted column for every signal
  for (genvar k = 0; k < NUM_SIG; k++) begin : g_col
    assign colVec[2*k]   = sigVec[k];
    assign colVec[2*k+1] = ~sigVec[k];
  end

  // AND plane: unconnected columns read as 1
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign rowVal[r] = &(colVec | ~fuseMap[r]);
  end

  // Fixed OR plane and output cells
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    sop_macrocell #(.NUM_TERMS(NUM_TERMS)) u_cell (
      .arch     (arch),
      .cellLocal(cellLocal[i]),
      .cellPol  (cellPol[i]),
      .terms    (rowVal[i*NUM_TERMS +: NUM_TERMS]),
      .regQ     (regQ[i]),
      .gateN    (gateN),
      .regD     (regD[i]),
      .cellOut  (ioOut[i]),
      .cellOe   (cellOe[i])
    );

    // R8
    reg_oe_chk: assert property (@(posedge clk) disable iff (rst)
      (arch == ARCH_REG && !cellLocal[i] && !strobes.block) |-> (ioOe[i] == !gateN));

    // R5
    simple_input_chk: assert property (@(posedge clk) disable iff (rst)
      (arch == ARCH_SIMPLE && cellLocal[i]) |-> !ioOe[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)                  regQ <= '0;
    else if (strobes.preload) regQ <= preData;
    else if (strobes.capture) regQ <= regD;
  end

  assign ioOe = cellOe & {NUM_CELLS{~strobes.block}};

  // R11
  preload_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.preload |=> (regQ == $past(preData)));

  // R12
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.preload && !strobes.capture) |=> $stable(regQ));

endmodule

// File: rtl/sop_fabric.sv
module sop_fabric
  import sop_pkg::*;
#(
  parameter int NUM_IN    = 8,
  parameter int NUM_CELLS = 8,
  parameter int NUM_TERMS = 8,
  localparam int NUM_COLS = 2 * (NUM_IN + NUM_CELLS),
  localparam int NUM_ROWS = NUM_CELLS * NUM_TERMS,
  localparam int ADDR_W   = $clog2(NUM_ROWS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfgEn,
  input  logic                  cfgWe,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [NUM_COLS-1:0]   cfgData,
  input  logic [NUM_IN-1:0]     din,
  input  logic                  ckPin,
  input  logic                  gateN,
  input  logic [NUM_CELLS-1:0]  ioIn,
  input  logic                  preEn,
  input  logic [NUM_CELLS-1:0]  preData,
  output logic [NUM_CELLS-1:0]  ioOut,
  output logic [NUM_CELLS-1:0]  ioOe
);

  logic [NUM_ROWS-1:0][NUM_COLS-1:0] fuseMap;
  arch_e                             arch;
  logic [NUM_CELLS-1:0]              cellLocal;
  logic [NUM_CELLS-1:0]              cellPol;
  strobe_t                           strobes;

  sop_ctrl #(
    .NUM_CELLS(NUM_CELLS),
    .NUM_TERMS(NUM_TERMS),
    .NUM_COLS (NUM_COLS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfgEn    (cfgEn),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .ckPin    (ckPin),
    .preEn    (preEn),
    .fuseMap  (fuseMap),
    .arch     (arch),
    .cellLocal(cellLocal),
    .cellPol  (cellPol),
    .strobes  (strobes)
  );

  sop_datapath #(
    .NUM_IN   (NUM_IN),
    .NUM_CELLS(NUM_CELLS),
    .NUM_TERMS(NUM_TERMS)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .arch     (arch),
    .cellLocal(cellLocal),
    .cellPol  (cellPol),
    .fuseMap  (fuseMap),
    .din      (din),
    .ckPin    (ckPin),
    .gateN    (gateN),
    .ioIn     (ioIn),
    .preData  (preData),
    .ioOut    (ioOut),
    .ioOe     (ioOe)
  );

  // R3
  cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
    cfgEn |-> (ioOe == '0));

endmodule

// File: tb/sop_fabric_bench.sv
module sop_fabric_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfgEn, cfgWe;
  logic [6:0]  cfgAddr;
  logic [31:0] cfgData;
  logic [7:0]  din, ioIn, preData;
  logic        ckPin, gateN, preEn;
  logic [7:0]  ioOut, ioOe;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  sop_fabric u_sop_fabric (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .din(din), .ckPin(ckPin), .gateN(gateN), .ioIn(ioIn),
    .preEn(preEn), .preData(preData), .ioOut(ioOut), .ioOe(ioOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tru(input int k);
    return 32'h1 << (2 * k);
  endfunction

  function automatic logic [31:0] inv(input int k);
    return 32'h1 << (2 * k + 1);
  endfunction

  function automatic logic [31:0] modeWord(input logic combArch, input logic cplx,
                                           input logic [7:0] loc, input logic [7:0] pol);
    return {8'h00, pol, loc, 6'h00, cplx, combArch};
  endfunction

  task automatic cfgWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic clearRows();
    for (int r = 0; r < 64; r++) cfgWrite(7'(r), 32'hFFFF_FFFF);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    step();
    check("R1 oe after reset", ioOe, 8'h00);
    check("R1 value after reset", ioOut, 8'h00);
  endtask

  task automatic t_simple();
    cfgEn = 1'b1;
    clearRows();
    cfgWrite(7'd0, tru(0) | inv(1));
    cfgWrite(7'd11, 32'h0);
    cfgWrite(7'd16, tru(0) | inv(0));
    cfgWrite(7'd64, modeWord(1'b1, 1'b0, 8'h80, 8'hFF));
    step();
    check("R3 oe held off during config", ioOe, 8'h00);
    cfgEn = 1'b0; din = 8'h01;
    step();
    check("R5 simple enables", ioOe, 8'h7F);
    check("R2 R4 R5 simple din=01", ioOut, 8'h03);
    din = 8'h03;
    step();
    check("R4 simple din=03", ioOut, 8'h02);
    din = 8'h00;
    step();
    check("R4 empty term and both-form term din=00", ioOut, 8'h02);
  endtask

  task automatic t_complex();
    cfgEn = 1'b1;
    clearRows();
    cfgWrite(7'd0, tru(0) | inv(1));
    cfgWrite(7'd24, tru(2));
    cfgWrite(7'd25, tru(3));
    cfgWrite(7'd64, modeWord(1'b1, 1'b1, 8'h00, 8'hFE));
    step();
    cfgEn = 1'b0; din = 8'h0C;
    step();
    check("R6 complex oe din=0C", ioOe, 8'h08);
    check("R6 R7 complex value din=0C", ioOut, 8'h09);
    din = 8'h08;
    step();
    check("R6 complex oe din=08", ioOe, 8'h00);
    din = 8'h05;
    step();
    check("R6 complex oe din=05", ioOe, 8'h09);
    check("R6 R7 complex value din=05", ioOut, 8'h01);
  endtask

  task automatic t_feedback();
    cfgEn = 1'b1;
    clearRows();
    cfgWrite(7'd32, 32'h0);
    cfgWrite(7'd33, tru(12));
    cfgWrite(7'd40, 32'h0);
    cfgWrite(7'd41, tru(8));
    cfgWrite(7'd48, 32'h0);
    cfgWrite(7'd49, tru(15));
    cfgWrite(7'd64, modeWord(1'b1, 1'b1, 8'h00, 8'hFF));
    step();
    cfgEn = 1'b0; din = 8'h00; ioIn = 8'h10; ckPin = 1'b0; gateN = 1'b0;
    step();
    check("R10 pin feedback enables", ioOe & 8'h70, 8'h70);
    check("R10 pin feedback of cell 4", ioOut & 8'h70, 8'h10);
    ioIn = 8'h00; ckPin = 1'b1;
    step();
    check("R10 clock pin as array input", ioOut & 8'h70, 8'h20);
    ckPin = 1'b0; gateN = 1'b1;
    step();
    check("R10 enable pin as array input", ioOut & 8'h70, 8'h40);
    gateN = 1'b0;
  endtask

  task automatic t_registered();
    cfgEn = 1'b1; ckPin = 1'b0;
    clearRows();
    cfgWrite(7'd0, tru(0));
    cfgWrite(7'd8, tru(1));
    cfgWrite(7'd9, tru(2));
    cfgWrite(7'd16, tru(8));
    cfgWrite(7'd64, modeWord(1'b0, 1'b0, 8'h02, 8'hF7));
    step();
    cfgEn = 1'b0; din = 8'h01; gateN = 1'b0;
    step();
    check("R12 hold while clock pin low", ioOut & 8'h0D, 8'h08);
    ckPin = 1'b1;
    step();
    check("R8 R7 first load", ioOut & 8'h0D, 8'h09);
    check("R8 registered enable with gate low", ioOe & 8'hFD, 8'hFD);
    step();
    check("R10 register feedback one edge later", ioOut & 8'h0D, 8'h0D);
    ckPin = 1'b0; gateN = 1'b1;
    step();
    check("R8 registered enable with gate high", ioOe & 8'hFD, 8'h00);
    gateN = 1'b0; din = 8'h06;
    step();
    check("R9 comb cell driven", {6'b0, ioOe[1], ioOut[1]}, 8'h03);
    din = 8'h04;
    step();
    check("R9 comb cell enable off", {6'b0, ioOe[1], ioOut[1]}, 8'h01);
    din = 8'h02;
    step();
    check("R9 comb cell value low", {6'b0, ioOe[1], ioOut[1]}, 8'h02);
  endtask

  task automatic t_preload();
    din = 8'h00; preEn = 1'b1; preData = 8'hA5; ckPin = 1'b1;
    step();
    preEn = 1'b0; ckPin = 1'b0;
    check("R11 preload over load", ioOut & 8'hFD, 8'hAD);
    step();
    check("R12 hold after preload", ioOut & 8'hFD, 8'hAD);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    step();
    check("R1 oe after second reset", ioOe, 8'h00);
    cfgEn = 1'b1;
    cfgWrite(7'd64, modeWord(1'b0, 1'b0, 8'h00, 8'hFF));
    step();
    cfgEn = 1'b0; ckPin = 1'b0; gateN = 1'b0;
    step();
    check("R1 registers cleared", ioOut, 8'h00);
    check("R1 registered cells driven", ioOe, 8'hFF);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; cfgEn = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0;
    din = '0; ioIn = '0; preData = '0; ckPin = 1'b0; gateN = 1'b0; preEn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_simple();
    t_complex();
    t_feedback();
    t_registered();
    t_preload();
    t_reset_again();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule